// File: doc/BRIEF.md
# Flash Erase Status Word Generator

This block models, on the device side, the word a flash array returns on reads while an embedded erase is pending, running, suspended or has failed. It keeps a mask of the blocks selected for erase and a mask of the blocks that failed. For every read it chooses between the array data and a synthesized status word. Two toggle flip-flops give the status word its changing bits. The main toggle (bit 6) advances on every read while the erase is active. The block-selective toggle (bit 2) advances only on reads that land in a block of interest. Which blocks count depends on the current state.

A command decoder upstream turns bus cycles into single-cycle events: add block, whole-array erase, controller start, suspend, resume, and completion with a pass/fail flag plus a per-block failure vector. The read strobe is `rd_en`, and its block index is the top `BLK_W` bits of `rd_addr`. `rd_data` is combinational from the current state and the toggle values. A qualifying read flips the relevant toggle at the clock edge that ends the read cycle, so the next read sees the new value.

The sequencer has five states.
- `ST_READ` is normal read mode.
- `ST_ARMED` means an erase set is being collected and the controller has not started.
- `ST_ERASING` means the controller is running.
- `ST_SUSPENDED` means the erase is paused.
- `ST_FAILED` means the erase finished with an error.

The transitions are:
- read→armed on a block or whole-array erase command;
- armed→erasing on start;
- erasing→suspended on suspend;
- suspended→erasing on resume;
- erasing→read on successful completion;
- erasing→failed on failed completion.

Failed is left only through reset.

Top module: `erase_status_gen`

## Requirements
- R1: After reset the state is read mode, both masks are empty, both toggles are 0, and `rd_data` equals `array_data`.
- R2: A block erase command in read mode enters `ST_ARMED` with only the named block selected. While armed, the status word has bit 3 = 0.
- R3: Block erase commands in `ST_ARMED` add blocks to the set, including in the cycle of the start event. Commands in any other active state leave the set unchanged. Bit 3 reads 1 in `ST_ERASING`, `ST_SUSPENDED` and `ST_FAILED`.
- R4: A whole-array erase command in read mode selects every block. It takes priority over a block command in the same cycle.
- R5: The status word has bits 7, 4, 1 and 0 at 0. Bit 5 is 1 only in `ST_FAILED`. Bit 6 is the main toggle, and bit 2 is the block toggle.
- R6: The main toggle flips on each read in `ST_ARMED`, `ST_ERASING` and `ST_FAILED`, and holds on every other cycle. The block toggle flips on each read whose block is in the erase set during `ST_ARMED`, `ST_ERASING` or `ST_SUSPENDED`, and holds on every other cycle. Reads in read mode change neither toggle.
- R7: In `ST_SUSPENDED`, reads from blocks outside the erase set return `array_data`. Reads from inside the set return the status word, with the main toggle held.
- R8: A resume event in `ST_SUSPENDED` returns to `ST_ERASING`.
- R9: Completion without failure returns to read mode, clears the erase set and leaves the toggles as they were.
- R10: Completion with failure enters `ST_FAILED`. The error mask becomes the erase set ANDed with `fail_blocks`. Every read returns the status word, and the block toggle flips only for blocks in the error mask. The state persists until reset.
- R11: Completion takes priority over a suspend event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the state, both masks and both toggles |
| rd_en | input | 1 | Read strobe, one per read cycle |
| rd_addr | input | ADDR_W | Read address; the top BLK_W bits are the block index |
| array_data | input | DATA_W | Cell data for the addressed word |
| blk_erase_cmd | input | 1 | Add block `cmd_block` to the erase set |
| cmd_block | input | BLK_W | Block index for `blk_erase_cmd` |
| chip_erase_cmd | input | 1 | Select all blocks for erase |
| erase_start | input | 1 | Controller begins erasing |
| suspend_cmd | input | 1 | Pause the running erase |
| resume_cmd | input | 1 | Continue a suspended erase |
| erase_done | input | 1 | Erase finished this cycle |
| erase_fail | input | 1 | Qualifies `erase_done` as failed |
| fail_blocks | input | NUM_BLOCKS | Blocks that did not erase, sampled with a failed completion |
| rd_data | output | DATA_W | Array data or status word |

## Verification
The bench walks every block index as the primary erase target and pairs it with a second block added while armed. It reads every block in each of the armed, erasing, suspended, completed and failed phases, so the in-set and out-of-set toggle behaviour is told apart in each state. Odd targets end in failure with a failure vector that covers only part of the set. This separates blocks that erased from blocks that failed, and a set member that did not fail from one that did. Further directed sequences check that block commands are ignored after start and that completion wins over a same-cycle suspend. A whole-array erase runs with a simultaneous block command, and reads in read mode must not advance the toggles.

// File: rtl/erase_status_pkg.sv
package erase_status_pkg;

    typedef enum logic [2:0] {
        ST_READ,
        ST_ARMED,
        ST_ERASING,
        ST_SUSPENDED,
        ST_FAILED
    } erase_state_e;

    localparam int unsigned BIT_MAIN_TGL  = 6;
    localparam int unsigned BIT_ERROR     = 5;
    localparam int unsigned BIT_STARTED   = 3;
    localparam int unsigned BIT_BLOCK_TGL = 2;
    localparam int unsigned STATUS_W      = 8;

endpackage

// File: rtl/erase_seq_fsm.sv
module erase_seq_fsm
    import erase_status_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 8,
    localparam int unsigned BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  blk_erase_cmd,
    input  logic [BLK_W-1:0]      cmd_block,
    input  logic                  chip_erase_cmd,
    input  logic                  erase_start,
    input  logic                  suspend_cmd,
    input  logic                  resume_cmd,
    input  logic                  erase_done,
    input  logic                  erase_fail,
    input  logic [NUM_BLOCKS-1:0] fail_blocks,
    output erase_state_e          state,
    output logic [NUM_BLOCKS-1:0] erase_mask,
    output logic [NUM_BLOCKS-1:0] err_mask
);

    localparam logic [NUM_BLOCKS-1:0] ONE = {{(NUM_BLOCKS-1){1'b0}}, 1'b1};

    erase_state_e          state_d;
    logic [NUM_BLOCKS-1:0] emask_d, err_d, sel_oh;

    assign sel_oh = ONE << cmd_block;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_READ;
            erase_mask <= '0;
            err_mask   <= '0;
        end else begin
            state      <= state_d;
            erase_mask <= emask_d;
            err_mask   <= err_d;
        end
    end

    always_comb begin
        state_d = state;
        emask_d = erase_mask;
        err_d   = err_mask;
        unique case (state)
            ST_READ: begin
                if (chip_erase_cmd) begin
                    state_d = ST_ARMED;
                    emask_d = '1;
                end else if (blk_erase_cmd) begin
                    state_d = ST_ARMED;
                    emask_d = sel_oh;
                end
            end
            ST_ARMED: begin
                if (blk_erase_cmd) emask_d = erase_mask | sel_oh;
                if (erase_start)   state_d = ST_ERASING;
            end
            ST_ERASING: begin
                if (erase_done) begin
                    if (erase_fail) begin
                        state_d = ST_FAILED;
                        err_d   = erase_mask & fail_blocks;
                    end else begin
                        state_d = ST_READ;
                        emask_d = '0;
                    end
                end else if (suspend_cmd) begin
                    state_d = ST_SUSPENDED;
                end
            end
            ST_SUSPENDED: begin
                if (resume_cmd) state_d = ST_ERASING;
            end
            ST_FAILED: begin
                state_d = ST_FAILED;
            end
            default: state_d = ST_READ;
        endcase
    end

    // R2
    armed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && blk_erase_cmd && !chip_erase_cmd)
            |=> (state == ST_ARMED && $onehot(erase_mask)));

    // R3
    set_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDED) |=> $stable(erase_mask));

    // R10
    failed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAILED) |=> (state == ST_FAILED && $stable(err_mask)));

    // R11
    done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING && erase_done && !erase_fail)
            |=> (state == ST_READ && erase_mask == '0));

endmodule

// File: rtl/toggle_cell.sv
module toggle_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    output logic q
);

    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (upd) q <= ~q;
    end

    // R6
    tgl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));

endmodule

// File: rtl/status_word_mux.sv
module status_word_mux
    import erase_status_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 8,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned BLK_W = $clog2(NUM_BLOCKS)
) (
    input  erase_state_e          state,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic [NUM_BLOCKS-1:0] err_mask,
    input  logic                  rd_en,
    input  logic [BLK_W-1:0]      rd_block,
    input  logic [DATA_W-1:0]     array_data,
    input  logic                  main_tgl,
    input  logic                  blk_tgl,
    output logic                  main_upd,
    output logic                  blk_upd,
    output logic [DATA_W-1:0]     rd_data
);

    logic in_set, in_err, active;
    logic [DATA_W-1:0] word;

    assign in_set = erase_mask[rd_block];
    assign in_err = err_mask[rd_block];
    assign active = (state == ST_ARMED) || (state == ST_ERASING);

    always_comb begin
        main_upd = rd_en && (active || state == ST_FAILED);
        blk_upd  = rd_en && (((active || state == ST_SUSPENDED) && in_set) ||
                             (state == ST_FAILED && in_err));
    end

    always_comb begin
        word                = '0;
        word[BIT_MAIN_TGL]  = main_tgl;
        word[BIT_ERROR]     = (state == ST_FAILED);
        word[BIT_STARTED]   = (state != ST_ARMED);
        word[BIT_BLOCK_TGL] = blk_tgl;
        if (state == ST_READ || (state == ST_SUSPENDED && !in_set))
            rd_data = array_data;
        else
            rd_data = word;
    end

endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import erase_status_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 8,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned BLK_W = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [DATA_W-1:0]     array_data,
    input  logic                  blk_erase_cmd,
    input  logic [BLK_W-1:0]      cmd_block,
    input  logic                  chip_erase_cmd,
    input  logic                  erase_start,
    input  logic                  suspend_cmd,
    input  logic                  resume_cmd,
    input  logic                  erase_done,
    input  logic                  erase_fail,
    input  logic [NUM_BLOCKS-1:0] fail_blocks,
    output logic [DATA_W-1:0]     rd_data
);

    erase_state_e          state;
    logic [NUM_BLOCKS-1:0] erase_mask, err_mask;
    logic [1:0]            tgl_q, tgl_upd;
    logic [BLK_W-1:0]      rd_block;

    assign rd_block = rd_addr[ADDR_W-1 -: BLK_W];

    erase_seq_fsm #(.NUM_BLOCKS(NUM_BLOCKS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .blk_erase_cmd(blk_erase_cmd), .cmd_block(cmd_block),
        .chip_erase_cmd(chip_erase_cmd), .erase_start(erase_start),
        .suspend_cmd(suspend_cmd), .resume_cmd(resume_cmd),
        .erase_done(erase_done), .erase_fail(erase_fail),
        .fail_blocks(fail_blocks),
        .state(state), .erase_mask(erase_mask), .err_mask(err_mask)
    );

    for (genvar i = 0; i < 2; i++) begin : g_tgl
        toggle_cell u_tgl (
            .clk(clk), .rst_n(rst_n), .upd(tgl_upd[i]), .q(tgl_q[i])
        );
    end

    status_word_mux #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) u_mux (
        .state(state), .erase_mask(erase_mask), .err_mask(err_mask),
        .rd_en(rd_en), .rd_block(rd_block), .array_data(array_data),
        .main_tgl(tgl_q[0]), .blk_tgl(tgl_q[1]),
        .main_upd(tgl_upd[0]), .blk_upd(tgl_upd[1]),
        .rd_data(rd_data)
    );

    // R5
    err_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASING || state == ST_ARMED) |-> !rd_data[BIT_ERROR]);

    // R7
    susp_main_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPENDED) |=> $stable(tgl_q[0]));

endmodule

// File: tb/erase_status_gen_tb.sv
module erase_status_gen_tb;

    localparam int NB = 8;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_data;
    logic blk_erase_cmd = 1'b0;
    logic [BW-1:0] cmd_block = '0;
    logic chip_erase_cmd = 1'b0, erase_start = 1'b0, suspend_cmd = 1'b0;
    logic resume_cmd = 1'b0, erase_done = 1'b0, erase_fail = 1'b0;
    logic [NB-1:0] fail_blocks = '0;
    logic [DW-1:0] rd_data;

    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;

    // model: 0 read, 1 armed, 2 erasing, 3 suspended, 4 failed
    int m_st = 0;
    logic [NB-1:0] m_set = '0, m_err = '0;
    logic m6 = 1'b0, m2 = 1'b0;

    always #4 clk = ~clk;

    assign array_data = {rd_addr[3:0], rd_addr[7:4]} ^ 8'h3C;

    erase_status_gen u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .array_data(array_data), .blk_erase_cmd(blk_erase_cmd),
        .cmd_block(cmd_block), .chip_erase_cmd(chip_erase_cmd),
        .erase_start(erase_start), .suspend_cmd(suspend_cmd),
        .resume_cmd(resume_cmd), .erase_done(erase_done),
        .erase_fail(erase_fail), .fail_blocks(fail_blocks),
        .rd_data(rd_data)
    );

    function automatic logic [DW-1:0] expected(int st, logic [NB-1:0] set,
                                               logic [DW-1:0] arr, int b);
        if (st == 0 || (st == 3 && !set[b])) return arr;
        return {1'b0, m6, (st == 4), 1'b0, (st != 1), m2, 2'b00};
    endfunction

    // checks the combinational output now, then advances one clock
    task automatic tick(string req);
        int b;
        int ns;
        logic [NB-1:0] nset, nerr;
        logic n6, n2;
        logic [DW-1:0] exp_v;
        #1;
        b = int'(rd_addr[AW-1 -: BW]);
        exp_v = expected(m_st, m_set, array_data, b);
        vectors++;
        if (rd_data !== exp_v) begin
            errors++;
            $display("FAIL %s: st=%0d addr=%h rd_data=%h expected=%h",
                     req, m_st, rd_addr, rd_data, exp_v);
        end
        ns = m_st; nset = m_set; nerr = m_err; n6 = m6; n2 = m2;
        if (rd_en && (m_st == 1 || m_st == 2 || m_st == 4)) n6 = ~m6;
        if (rd_en && (((m_st >= 1 && m_st <= 3) && m_set[b]) ||
                      (m_st == 4 && m_err[b]))) n2 = ~m2;
        case (m_st)
            0: if (chip_erase_cmd) begin ns = 1; nset = '1; end
               else if (blk_erase_cmd) begin ns = 1; nset = NB'(1) << cmd_block; end
            1: begin
                if (blk_erase_cmd) nset = m_set | (NB'(1) << cmd_block);
                if (erase_start) ns = 2;
            end
            2: if (erase_done) begin
                   if (erase_fail) begin ns = 4; nerr = m_set & fail_blocks; end
                   else begin ns = 0; nset = '0; end
               end else if (suspend_cmd) ns = 3;
            3: if (resume_cmd) ns = 2;
            default: ;
        endcase
        if (!rst_n) begin ns = 0; nset = '0; nerr = '0; n6 = 0; n2 = 0; end
        @(posedge clk);
        m_st = ns; m_set = nset; m_err = nerr; m6 = n6; m2 = n2;
        @(negedge clk);
        rd_en = 0; blk_erase_cmd = 0; chip_erase_cmd = 0; erase_start = 0;
        suspend_cmd = 0; resume_cmd = 0; erase_done = 0; erase_fail = 0;
        rst_n = 1;
    endtask

    task automatic rd(int blk, int off, string req);
        rd_en = 1;
        rd_addr = AW'((blk << (AW - BW)) | off);
        tick(req);
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < NB; k++) rd(k, k * 3 + 1, req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick("R1");
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        read_all("R1");
        for (int b = 0; b < NB; b++) begin
            int other = (b + 3) % NB;
            int late  = (b + 5) % NB;
            blk_erase_cmd = 1; cmd_block = BW'(b); tick("R2");
            rd(b, 2, "R2"); rd(b, 4, "R6"); rd(other, 1, "R6");
            blk_erase_cmd = 1; cmd_block = BW'(other); tick("R3");
            rd(other, 5, "R3");
            erase_start = 1; tick("R3");
            blk_erase_cmd = 1; cmd_block = BW'(late); tick("R3");
            rd(late, 0, "R3"); rd(late, 7, "R3");
            read_all("R6");
            suspend_cmd = 1; tick("R7");
            read_all("R7"); read_all("R7");
            resume_cmd = 1; tick("R8");
            read_all("R8");
            if (b % 2 == 0) begin
                erase_done = 1; tick("R9");
                read_all("R9");
            end else begin
                erase_done = 1; erase_fail = 1;
                fail_blocks = (NB'(1) << b) | (NB'(1) << late);
                tick("R10");
                read_all("R10"); read_all("R10");
                suspend_cmd = 1; tick("R10");
                read_all("R10");
                do_reset();
            end
        end
        // R4: whole-array erase wins over same-cycle block command
        chip_erase_cmd = 1; blk_erase_cmd = 1; cmd_block = 3'd2; tick("R4");
        read_all("R4");
        erase_start = 1; tick("R4");
        read_all("R4");
        // R11: completion beats suspend
        erase_done = 1; suspend_cmd = 1; tick("R11");
        read_all("R11");
        // R6: read-mode reads leave toggles; observed in next erase
        read_all("R6");
        blk_erase_cmd = 1; cmd_block = 3'd6; tick("R6");
        rd(6, 1, "R6"); rd(0, 1, "R6");
        erase_start = 1; tick("R6");
        erase_done = 1; erase_fail = 1; fail_blocks = '1; tick("R10");
        read_all("R10");
        do_reset();
        read_all("R1");
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule